// File: doc/BRIEF.md
# Chiplet Control Register Bank

This block is a bank of 64-bit control and status registers that sits behind a simple synchronous register request port in a chip's pervasive control area. An upstream decoder turns each 8-byte bus access into a register index (byte address divided by eight) and presents it with a write flag and 64 bits of write data. The bank answers one clock later with registered read data, a response strobe and an error flag.

The bank holds six control words, two configuration words, and four single-view words: a status word, a mask word, a protect-mode word and an atomic-lock word. Each control and configuration word has three views. The base view can be read and written. A write-only set view ORs the write data into the word. A write-only clear view clears every bit that is set in the write data. Software can therefore change single bits without a read-modify-write sequence.

Reading a set or clear view, or any index outside the map, returns all ones and raises the error flag. Writing an index outside the map raises the error flag and changes nothing.

Top module: `chiplet_ctrl_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every register becomes zero, and so do rsp_valid, rsp_err and rsp_rdata.
- R2: A write to a base index replaces the whole word. A read of a base index in any later cycle returns that word in rsp_rdata one clock after the request, with rsp_valid high and rsp_err low.
- R3: Control word n (n = 0..5) has its base at index 0x00+n, its set view at 0x10+n and its clear view at 0x20+n. Configuration word 0 uses 0x08/0x18/0x28 and configuration word 1 uses 0x09/0x19/0x29. A write to a set view leaves the word as old OR data.
- R4: A write to a clear view leaves the word as old AND NOT data.
- R5: A read of a set or clear view returns all ones with rsp_err high and leaves every register unchanged.
- R6: A read of an unmapped index returns all ones with rsp_err high. A write to an unmapped index raises rsp_err and leaves every register unchanged.
- R7: The status word (0x100), the mask word (0x101), the protect-mode word (0x3FE) and the atomic-lock word (0x3FF) are plain read/write words. Indices 0x110, 0x120, 0x111, 0x3EE and similar have no alias meaning and are unmapped.
- R8: Every write response, including a write to a set or clear view, has rsp_rdata equal to zero. For a mapped write, rsp_err is low.
- R9: In the clock after a cycle with no request, rsp_valid and rsp_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 10 | Register index (byte address >> 3) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data; all ones on a failed read, zero on writes |
| rsp_err | output | 1 | Access was to an unmapped index or was a read of a write-only view |

## Verification
Assertions check the following on every cycle: the response strobe follows the request by one clock, a bad read returns all ones with the error flag, reads and unmapped writes leave the stored words untouched, the decode selects at most one view, and set, clear and base writes land with the right bit effect. Only the bench scenarios can show that the index map is correct as a whole. These scenarios are the table of directed accesses and a long random mix of base, set and clear writes, alias reads and unmapped accesses, all compared against a bench model of the twelve words. They also show that a value written is read back intact in the next cycle and that reset in the middle of a run clears the words.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
   // Kind of access presented at the request port in a given cycle
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   // Number of words that have a single (base) view only
   localparam int unsigned N_SINGLE = 4;
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode #(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned N_CTRL   = 6,
   parameter int unsigned N_CFG    = 2,
   parameter int unsigned CFG_BASE = 'h08,
   parameter int unsigned SET_OFS  = 'h10,
   parameter int unsigned CLR_OFS  = 'h20,
   parameter int unsigned STAT_IDX = 'h100,
   parameter int unsigned MASK_IDX = 'h101,
   parameter int unsigned PROT_IDX = 'h3FE,
   parameter int unsigned LOCK_IDX = 'h3FF,
   localparam int unsigned N_AL    = N_CTRL + N_CFG,
   localparam int unsigned N_REG   = N_AL + cpr_pkg::N_SINGLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [N_REG-1:0] base_sel,
   output logic [N_AL-1:0]  set_sel,
   output logic [N_AL-1:0]  clr_sel
);
   function automatic int unsigned base_of(int unsigned k);
      if (k < N_CTRL) return k;
      if (k < N_AL)   return CFG_BASE + k - N_CTRL;
      case (k - N_AL)
         0:       return STAT_IDX;
         1:       return MASK_IDX;
         2:       return PROT_IDX;
         default: return LOCK_IDX;
      endcase
   endfunction

   genvar k;
   generate
      for (k = 0; k < N_REG; k++) begin : g_sel
         localparam int unsigned BASE = base_of(k);
         assign base_sel[k] = (idx == IDX_W'(BASE));
         if (k < N_AL) begin : g_alias
            assign set_sel[k] = (idx == IDX_W'(BASE + SET_OFS));
            assign clr_sel[k] = (idx == IDX_W'(BASE + CLR_OFS));
         end
      end
   endgenerate

   // R3: an index selects at most one view of one word
   p_one_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({base_sel, set_sel, clr_sel}));
endmodule

// File: rtl/cpr_alias_cell.sv
module cpr_alias_cell #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         set,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
      else if (set)  q <= q | d;
      else if (clr)  q <= q & ~d;
   end

   p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set && !load |=> ((q & $past(d)) == $past(d)) &&
                       ((q & ~$past(d)) == ($past(q) & ~$past(d))));
   p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !load && !set |=> ((q & $past(d)) == '0) &&
                               ((q & ~$past(d)) == ($past(q) & ~$past(d))));
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));
endmodule

// File: rtl/cpr_plain_cell.sv
module cpr_plain_cell #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   p_plain_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));
endmodule

// File: rtl/chiplet_ctrl_bank.sv
module chiplet_ctrl_bank
   import cpr_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned N_CTRL   = 6,
   parameter int unsigned N_CFG    = 2,
   parameter int unsigned CFG_BASE = 'h08,
   parameter int unsigned SET_OFS  = 'h10,
   parameter int unsigned CLR_OFS  = 'h20,
   parameter int unsigned STAT_IDX = 'h100,
   parameter int unsigned MASK_IDX = 'h101,
   parameter int unsigned PROT_IDX = 'h3FE,
   parameter int unsigned LOCK_IDX = 'h3FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   localparam int unsigned N_AL  = N_CTRL + N_CFG;
   localparam int unsigned N_REG = N_AL + N_SINGLE;

   // Elaboration checks on the map layout
   generate
      if (N_CTRL + N_CFG == 0) begin : g_chk_empty
         $error("bank needs at least one aliased word");
      end
      if (N_CTRL > CFG_BASE) begin : g_chk_overlap
         $error("control words run into the configuration words");
      end
      if (CFG_BASE + N_CFG > SET_OFS || SET_OFS + CFG_BASE + N_CFG > CLR_OFS) begin : g_chk_alias
         $error("alias windows overlap");
      end
      if ((1 << IDX_W) <= LOCK_IDX || (1 << IDX_W) <= PROT_IDX) begin : g_chk_idx
         $error("index width too small for the single-view words");
      end
   endgenerate

   logic [N_REG-1:0] base_sel;
   logic [N_AL-1:0]  set_sel, clr_sel;

   cpr_decode #(
      .IDX_W(IDX_W), .N_CTRL(N_CTRL), .N_CFG(N_CFG), .CFG_BASE(CFG_BASE),
      .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .STAT_IDX(STAT_IDX),
      .MASK_IDX(MASK_IDX), .PROT_IDX(PROT_IDX), .LOCK_IDX(LOCK_IDX)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .idx(req_idx),
      .base_sel(base_sel), .set_sel(set_sel), .clr_sel(clr_sel)
   );

   acc_kind_e kind;
   always_comb begin
      if (!req_valid)     kind = ACC_IDLE;
      else if (req_write) kind = ACC_WRITE;
      else                kind = ACC_READ;
   end

   logic                base_hit, any_hit;
   logic                wr_en;
   logic [DATA_W-1:0]   words [N_REG];
   logic [N_REG*DATA_W-1:0] flat;

   assign base_hit = |base_sel;
   assign any_hit  = base_hit | (|set_sel) | (|clr_sel);
   assign wr_en    = (kind == ACC_WRITE);

   genvar k;
   generate
      for (k = 0; k < N_REG; k++) begin : g_word
         if (k < N_AL) begin : g_al
            cpr_alias_cell #(.W(DATA_W)) u_cell (
               .clk(clk), .rst_n(rst_n),
               .load(wr_en & base_sel[k]),
               .set(wr_en & set_sel[k]),
               .clr(wr_en & clr_sel[k]),
               .d(req_wdata), .q(words[k])
            );
         end else begin : g_pl
            cpr_plain_cell #(.W(DATA_W)) u_cell (
               .clk(clk), .rst_n(rst_n),
               .load(wr_en & base_sel[k]),
               .d(req_wdata), .q(words[k])
            );
         end
         assign flat[k*DATA_W +: DATA_W] = words[k];
      end
   endgenerate

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < N_REG; i++)
         if (base_sel[i]) rd_mux = rd_mux | words[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= (kind != ACC_IDLE);
         case (kind)
            ACC_READ: begin
               rsp_rdata <= base_hit ? rd_mux : '1;
               rsp_err   <= !base_hit;
            end
            ACC_WRITE: begin
               rsp_rdata <= '0;
               rsp_err   <= !any_hit;
            end
            default: begin
               rsp_rdata <= '0;
               rsp_err   <= 1'b0;
            end
         endcase
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (flat == '0) && !rsp_valid && !rsp_err);
   p_rsp_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_bad_read_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && !base_hit |=> rsp_err && (rsp_rdata == '1));
   // R5: no read, of any view, alters a stored word
   p_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> $stable(flat));
   p_bad_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && !any_hit |=> $stable(flat) && rsp_err);
   p_write_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> rsp_rdata == '0);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_err);
endmodule

// File: tb/chiplet_ctrl_bank_test.sv
module chiplet_ctrl_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [9:0]  req_idx = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        rsp_err;

   chiplet_ctrl_bank uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   logic [63:0] model [12];

   always @(posedge clk) begin
      cycles++;
      if (cycles > MAX_CYCLES) begin
         failures++;
         $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYCLES);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string rq, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // Called at a falling edge; returns the response sampled one clock later
   task automatic access(input bit wr, input logic [9:0] idx, input logic [63:0] d,
                         output logic [63:0] rd, output logic er, output logic vl);
      req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = d;
      @(negedge clk);
      rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // Bench view of the map: kind 0 unmapped, 1 base, 2 set, 3 clear
   function automatic void classify(input logic [9:0] idx, output int kind, output int r);
      kind = 0; r = -1;
      case (idx)
         10'h000, 10'h001, 10'h002, 10'h003, 10'h004, 10'h005: begin kind = 1; r = int'(idx); end
         10'h008: begin kind = 1; r = 6; end
         10'h009: begin kind = 1; r = 7; end
         10'h100: begin kind = 1; r = 8; end
         10'h101: begin kind = 1; r = 9; end
         10'h3FE: begin kind = 1; r = 10; end
         10'h3FF: begin kind = 1; r = 11; end
         10'h010, 10'h011, 10'h012, 10'h013, 10'h014, 10'h015: begin kind = 2; r = int'(idx) - 'h10; end
         10'h018: begin kind = 2; r = 6; end
         10'h019: begin kind = 2; r = 7; end
         10'h020, 10'h021, 10'h022, 10'h023, 10'h024, 10'h025: begin kind = 3; r = int'(idx) - 'h20; end
         10'h028: begin kind = 3; r = 6; end
         10'h029: begin kind = 3; r = 7; end
         default: ;
      endcase
   endfunction

   typedef struct packed {
      logic        wr;
      logic [9:0]  idx;
      logic [63:0] d;
      logic [63:0] exp;
      logic        err;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 10'h000, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 4'd2},
      '{1'b0, 10'h000, 64'h0, 64'h1234_5678_9ABC_DEF0, 1'b0, 4'd2},
      '{1'b1, 10'h010, 64'h0000_0000_0000_000F, 64'h0, 1'b0, 4'd8},
      '{1'b0, 10'h000, 64'h0, 64'h1234_5678_9ABC_DEFF, 1'b0, 4'd3},
      '{1'b1, 10'h020, 64'h0000_0000_0000_0003, 64'h0, 1'b0, 4'd8},
      '{1'b0, 10'h000, 64'h0, 64'h1234_5678_9ABC_DEFC, 1'b0, 4'd4},
      '{1'b0, 10'h010, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd5},
      '{1'b0, 10'h025, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd5},
      '{1'b0, 10'h000, 64'h0, 64'h1234_5678_9ABC_DEFC, 1'b0, 4'd5},
      '{1'b1, 10'h009, 64'hFFFF_0000_FFFF_0000, 64'h0, 1'b0, 4'd2},
      '{1'b1, 10'h029, 64'h0000_0000_FFFF_FFFF, 64'h0, 1'b0, 4'd4},
      '{1'b0, 10'h009, 64'h0, 64'hFFFF_0000_0000_0000, 1'b0, 4'd4},
      '{1'b1, 10'h018, 64'h00F0_0000_0000_0001, 64'h0, 1'b0, 4'd3},
      '{1'b0, 10'h008, 64'h0, 64'h00F0_0000_0000_0001, 1'b0, 4'd3},
      '{1'b1, 10'h100, 64'hA5A5_A5A5_A5A5_A5A5, 64'h0, 1'b0, 4'd7},
      '{1'b1, 10'h3FF, 64'h8000_0000_0000_0001, 64'h0, 1'b0, 4'd7},
      '{1'b1, 10'h110, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 4'd7},
      '{1'b0, 10'h100, 64'h0, 64'hA5A5_A5A5_A5A5_A5A5, 1'b0, 4'd7},
      '{1'b0, 10'h3FF, 64'h0, 64'h8000_0000_0000_0001, 1'b0, 4'd7},
      '{1'b0, 10'h00A, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd6},
      '{1'b1, 10'h006, 64'h5555_5555_5555_5555, 64'h0, 1'b1, 4'd6},
      '{1'b0, 10'h005, 64'h0, 64'h0, 1'b0, 4'd6}
   };

   initial begin
      logic [63:0] rd;
      logic er, vl;
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 rsp idle after reset", {62'b0, rsp_valid, rsp_err}, 64'h0);
      check(rsp_rdata == 64'h0, "R1 rdata zero after reset", rsp_rdata, 64'h0);
      foreach (model[i]) model[i] = '0;
      for (int i = 0; i < 12; i++) begin
         logic [9:0] bi;
         bi = (i < 6) ? 10'(i) : (i == 6) ? 10'h008 : (i == 7) ? 10'h009 :
              (i == 8) ? 10'h100 : (i == 9) ? 10'h101 : (i == 10) ? 10'h3FE : 10'h3FF;
         access(1'b0, bi, '0, rd, er, vl);
         check(rd == 64'h0 && !er, "R1 word zero after reset", rd, 64'h0);
      end

      // Table walk
      for (int v = 0; v < NV; v++) begin
         access(VECS[v].wr, VECS[v].idx, VECS[v].d, rd, er, vl);
         check(vl && rd == VECS[v].exp, $sformatf("R%0d vector %0d data", VECS[v].rq, v), rd, VECS[v].exp);
         check(er == VECS[v].err, $sformatf("R%0d vector %0d err", VECS[v].rq, v), 64'(er), 64'(VECS[v].err));
      end

      // R9: idle cycle after a request
      @(negedge clk);
      check(!rsp_valid && !rsp_err, "R9 idle response", {62'b0, rsp_valid, rsp_err}, 64'h0);

      // Mid-run reset (R1): words written above must clear
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b0, 10'h000, '0, rd, er, vl);
      check(rd == 64'h0, "R1 mid-run reset clears control word 0", rd, 64'h0);
      access(1'b0, 10'h100, '0, rd, er, vl);
      check(rd == 64'h0, "R1 mid-run reset clears status word", rd, 64'h0);

      // Random mix against the bench model (R2..R8)
      foreach (model[i]) model[i] = '0;
      for (int n = 0; n < 3000; n++) begin
         logic [9:0]  idx;
         logic [63:0] d, exp;
         bit          wr, eerr;
         int          kind, r, pick;
         pick = int'($urandom % 4);
         case (pick)
            0: idx = 10'($urandom);
            1: idx = 10'($urandom % 'h30);
            2: idx = (($urandom % 2) != 0) ? 10'h100 + 10'($urandom % 2) : 10'h3FE + 10'($urandom % 2);
            default: idx = 10'($urandom % 10) + ((($urandom % 3) == 0) ? 10'h0 : (($urandom % 2) != 0) ? 10'h10 : 10'h20);
         endcase
         wr = ($urandom % 2) != 0;
         d = {$urandom, $urandom};
         classify(idx, kind, r);
         if (wr) begin
            exp = '0;
            eerr = (kind == 0);
            if (kind == 1) model[r] = d;
            else if (kind == 2) model[r] = model[r] | d;
            else if (kind == 3) model[r] = model[r] & ~d;
         end else begin
            eerr = (kind != 1);
            exp = (kind == 1) ? model[r] : '1;
         end
         access(wr, idx, d, rd, er, vl);
         check(vl && rd == exp, $sformatf("R%0d random op %0d idx %h data",
               wr ? ((kind == 2) ? 3 : (kind == 3) ? 4 : (kind == 0) ? 6 : 2)
                  : ((kind == 1) ? 2 : (kind == 0) ? 6 : 5), n, idx), rd, exp);
         check(er == eerr, $sformatf("R8 random op %0d idx %h err", n, idx), 64'(er), 64'(eerr));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule